// File: doc/BRIEF.md
# Coin-Operated Water Dispenser Controller

This block is a synchronous Mealy state machine that controls a bottled-water dispenser. Coins enter through one slot. Two single-cycle pulse inputs report them: one pulse for a 10-unit coin (a whole Yuan) and one for a 5-unit coin (half a Yuan). A bottle is released once the credit collected reaches 10 units. The release is signalled by a one-cycle pulse on `dispense`, raised in the same cycle as the coin that completes the price. The machine then returns to zero credit. It gives no change, so a whole coin added on top of a half coin releases a bottle and the surplus is lost.

The controller stores one bit of state and has two states. `ST_EMPTY` holds no credit and `ST_HALF` holds 5 units. The named transitions are:

- EMPTY_TEN: a whole coin while empty. The machine dispenses and stays in `ST_EMPTY`.
- EMPTY_FIVE: a half coin while empty. The machine goes to `ST_HALF` and does not dispense.
- HALF_FIVE: a half coin while in `ST_HALF`. The machine dispenses and goes to `ST_EMPTY`.
- HALF_TEN: a whole coin while in `ST_HALF`. The machine dispenses and goes to `ST_EMPTY`, and the surplus is dropped.
- HOLD: no coin in the cycle. The state does not change.
- CLASH: both coin pulses high in the same cycle. This is treated as no coin and the state does not change.

Reset is synchronous and returns the machine to `ST_EMPTY`.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `ST_EMPTY`, and `dispense` is low for the whole time `rst` is high. After reset is released, the first half coin does not dispense.
- R2: In `ST_EMPTY`, a whole-coin pulse alone drives `dispense` high in that same cycle, and the state stays `ST_EMPTY`.
- R3: In `ST_EMPTY`, a half-coin pulse alone leaves `dispense` low, and the state moves to `ST_HALF`.
- R4: In `ST_HALF`, a half-coin pulse alone drives `dispense` high in that cycle, and the state returns to `ST_EMPTY`.
- R5: In `ST_HALF`, a whole-coin pulse alone drives `dispense` high in that cycle, and the state returns to `ST_EMPTY`. The surplus 5 units are discarded, so the next half coin does not dispense.
- R6: In a cycle with neither coin input high, `dispense` is low and the state is held.
- R7: In a cycle with both coin inputs high, `dispense` is low and the state is held, in either state.
- R8: `dispense` is high only in the cycle of the qualifying coin pulse. Back-to-back whole coins each produce their own one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_five | input | 1 | One-cycle pulse: a 5-unit coin was inserted |
| coin_ten | input | 1 | One-cycle pulse: a 10-unit coin was inserted |
| dispense | output | 1 | Mealy output: release one bottle this cycle |

## Verification
The assertions assume that both coin inputs change only between rising clock edges and that reset is held from time zero until after the first edge, so the state register is defined before any property is evaluated. They treat a simultaneous pair of pulses as a legal input. The stimulus therefore drives the coin inputs at falling edges, keeps reset high through the first edges, and deliberately includes clashing pulses in both states. It samples `dispense` shortly after each falling edge, where the combinational Mealy result has settled for the current coin.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Credit held by the controller
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HALF  = 1'b1
    } vend_state_e;

    // Classified slot event for one cycle
    typedef enum logic [1:0] {
        COIN_NONE  = 2'd0,
        COIN_FIVE  = 2'd1,
        COIN_TEN   = 2'd2,
        COIN_CLASH = 2'd3
    } coin_e;

endpackage

// File: rtl/vend_coin_classify.sv
module vend_coin_classify
    import vend_pkg::*;
(
    input  logic  coin_five,
    input  logic  coin_ten,
    output coin_e kind
);

    always_comb begin
        unique case ({coin_ten, coin_five})
            2'b00:   kind = COIN_NONE;
            2'b01:   kind = COIN_FIVE;
            2'b10:   kind = COIN_TEN;
            default: kind = COIN_CLASH;
        endcase
    end

endmodule

// File: rtl/vend_step.sv
module vend_step
    import vend_pkg::*;
(
    input  vend_state_e state,
    input  coin_e       kind,
    output vend_state_e next_state,
    output logic        vend
);

    always_comb begin
        next_state = state;
        vend       = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                unique case (kind)
                    COIN_TEN:  vend = 1'b1;             // EMPTY_TEN
                    COIN_FIVE: next_state = ST_HALF;    // EMPTY_FIVE
                    default:   next_state = ST_EMPTY;   // HOLD / CLASH
                endcase
            end
            ST_HALF: begin
                unique case (kind)
                    COIN_FIVE, COIN_TEN: begin          // HALF_FIVE / HALF_TEN
                        vend       = 1'b1;
                        next_state = ST_EMPTY;
                    end
                    default:   next_state = ST_HALF;    // HOLD / CLASH
                endcase
            end
            default: next_state = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_five,
    input  logic coin_ten,
    output logic dispense
);

    coin_e       kind;
    vend_state_e state_q;
    vend_state_e state_d;
    logic        vend_raw;

    vend_coin_classify u_classify (
        .coin_five (coin_five),
        .coin_ten  (coin_ten),
        .kind      (kind)
    );

    vend_step u_step (
        .state      (state_q),
        .kind       (kind),
        .next_state (state_d),
        .vend       (vend_raw)
    );

    // State register, synchronous reset
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Mealy output, held low during reset
    always_comb begin
        dispense = vend_raw & ~rst;
    end

    // R2: whole coin while empty dispenses and stays empty
    p_empty_ten_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY && coin_ten && !coin_five) |-> dispense)
        else $error("p_empty_ten_r2");
    p_empty_ten_stay_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY && coin_ten && !coin_five) |=> state_q == ST_EMPTY)
        else $error("p_empty_ten_stay_r2");

    // R3: half coin while empty moves to half credit silently
    p_empty_five_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY && coin_five && !coin_ten) |=> state_q == ST_HALF)
        else $error("p_empty_five_r3");

    // R4 / R5: any single coin in half credit dispenses and clears
    p_half_coin_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALF && (coin_five ^ coin_ten)) |-> dispense)
        else $error("p_half_coin_r4");
    p_half_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALF && (coin_five ^ coin_ten)) |=> state_q == ST_EMPTY)
        else $error("p_half_clear_r5");

    // R6: idle slot holds state
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!coin_five && !coin_ten) |-> (!dispense ##1 $stable(state_q)))
        else $error("p_idle_hold_r6");

    // R7: clashing pulses are ignored
    p_clash_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (coin_five && coin_ten) |-> (!dispense ##1 $stable(state_q)))
        else $error("p_clash_hold_r7");

    // R8: dispense only accompanies exactly one coin pulse
    p_pulse_needs_coin_r8: assert property (@(posedge clk) disable iff (rst)
        dispense |-> (coin_five ^ coin_ten))
        else $error("p_pulse_needs_coin_r8");

endmodule

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_five = 1'b0;
    logic coin_ten = 1'b0;
    logic dispense;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .coin_five (coin_five),
        .coin_ten  (coin_ten),
        .dispense  (dispense)
    );

    task automatic check(input logic actual, input logic expected, input string tag);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: dispense actual=%0b expected=%0b", tag, actual, expected);
        end
    endtask

    // Present one cycle of slot input and check the Mealy output for it
    task automatic drive(input logic five, input logic ten, input logic exp, input string tag);
        @(negedge clk);
        coin_five = five;
        coin_ten  = ten;
        #1;
        check(dispense, exp, tag);
    endtask

    task automatic test_reset();
        drive(1'b0, 1'b1, 1'b0, "R1 no dispense in reset (ten)");
        drive(1'b1, 1'b0, 1'b0, "R1 no dispense in reset (five)");
        @(negedge clk);
        coin_five = 1'b0;
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, "R1 empty after reset");
        drive(1'b1, 1'b0, 1'b1, "R4 leave half after reset probe");
    endtask

    task automatic test_empty_ten();
        drive(1'b0, 1'b1, 1'b1, "R2 whole coin dispenses");
        drive(1'b0, 1'b0, 1'b0, "R6 idle after whole coin");
        drive(1'b1, 1'b0, 1'b0, "R2 stayed empty");
        drive(1'b1, 1'b0, 1'b1, "R4 cleanup");
    endtask

    task automatic test_half_half();
        drive(1'b1, 1'b0, 1'b0, "R3 half coin no dispense");
        drive(1'b0, 1'b0, 1'b0, "R6 hold half credit 1");
        drive(1'b0, 1'b0, 1'b0, "R6 hold half credit 2");
        drive(1'b1, 1'b0, 1'b1, "R4 second half dispenses");
        drive(1'b1, 1'b0, 1'b0, "R4 returned to empty");
        drive(1'b1, 1'b0, 1'b1, "R4 cleanup");
    endtask

    task automatic test_half_ten();
        drive(1'b1, 1'b0, 1'b0, "R3 enter half");
        drive(1'b0, 1'b1, 1'b1, "R5 whole coin on half dispenses");
        drive(1'b1, 1'b0, 1'b0, "R5 surplus discarded");
        drive(1'b0, 1'b1, 1'b1, "R5 whole coin on half again");
    endtask

    task automatic test_clash();
        drive(1'b1, 1'b1, 1'b0, "R7 clash in empty");
        drive(1'b1, 1'b0, 1'b0, "R7 empty held after clash");
        drive(1'b1, 1'b1, 1'b0, "R7 clash in half");
        drive(1'b0, 1'b0, 1'b0, "R6 idle in half");
        drive(1'b0, 1'b1, 1'b1, "R7 half held after clash");
    endtask

    task automatic test_back_to_back();
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, 1'b1, 1'b1, "R8 back-to-back whole coin");
        end
        drive(1'b0, 1'b0, 1'b0, "R8 pulse ends with coin");
    endtask

    task automatic test_mid_reset();
        drive(1'b1, 1'b0, 1'b0, "R3 enter half before reset");
        @(negedge clk);
        coin_five = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b0, "R1 reset cleared credit");
        drive(1'b1, 1'b0, 1'b1, "R4 cleanup after reset");
        drive(1'b0, 1'b0, 1'b0, "R6 final idle");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_empty_ten();
        test_half_half();
        test_half_ten();
        test_clash();
        test_back_to_back();
        test_mid_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule